// File: doc/BRIEF.md
# 256b/257b Block Transcoder

This block folds four consecutive 66-bit line blocks into one 257-bit transcoded word. Each 66-bit input word carries a 2-bit sync header and a 64-bit payload. When all four words are data, the transcoded word is a single header bit of 1 followed by the four payloads. When any of the four is a control block, the header bit is 0. The 8-bit type field of the first control block is then cut down to its low nibble. The four bits this frees hold a data/control mask, and that mask makes room for the 1-bit transcoded header.

The type field can be cut safely because its two nibbles form a distance-4 codeword, so a receiver can rebuild the missing nibble. Only the sync headers steer the packing, and they are never scrambled. The block therefore gives the same result on scrambled and unscrambled payloads. All four words are presented in parallel with a valid strobe. The result appears one clock later with its own valid strobe and an error flag for malformed sync headers.

Top module: `xc257_transcoder`

## Requirements
- R1: An input word's sync header is its bits [1:0], with bit 0 sent first. The value 2'b10 (line order 0 then 1) marks a data block. Every other value is treated as a control block for packing, and 2'b01 is the legal control code.
- R2: When all four blocks are data, output bit 0 is 1 and block k's 64-bit payload (input bits [66k+65:66k+2]) appears at output bits [64k+64:64k+1].
- R3: When at least one block is control, output bit 0 is 0 and output bit 1+k is 1 if block k is data and 0 if it is control. With four blocks this is one mask bit per block.
- R4: In the mixed case, the first control block (lowest index) keeps only payload bits [3:0] and [63:8]. Bits [3:0] of its type field come first, followed by bits [63:8]. Its bits [7:4] are dropped.
- R5: In the mixed case, the blocks are packed in index order starting at output bit 5. Data blocks and every control block after the first keep their full 64-bit payload, and a block placed after the compressed one starts 4 bits lower than its uncompressed position.
- R6: If any block carries a sync header of 2'b00 or 2'b11, out_err is 1 with that transcoded word, and the word is still emitted with out_valid.
- R7: out_valid is 1 exactly one cycle after a cycle in which in_valid is 1.
- R8: A synchronous reset makes out_valid 0 on the cycle after it is sampled.
- R9: out_block and out_err hold their value in cycles with no valid input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | The four input words are valid this cycle |
| in_blocks | input | 264 | Block k in bits [66k+65:66k], sync header in the low 2 bits |
| out_valid | output | 1 | out_block holds a new transcoded word |
| out_block | output | 257 | Transcoded word, bit 0 sent first |
| out_err | output | 1 | Malformed sync header seen in this word |

## Verification
Two things can be decided in the same cycle: the compression of the first control block's type field and the reporting of a malformed header. A malformed header counts as a control block, so it can itself become the block that is compressed. The bench provokes this with directed words that place an invalid header before, at and after the first legal control block. It also mixes invalid headers into random traffic. Each result is judged against a reference that packs the bit stream one position at a time and separately expects the error flag.

// File: rtl/xc257_pkg.sv
package xc257_pkg;
   localparam int unsigned XC_HDR_W   = 2;
   localparam int unsigned XC_PAY_W   = 64;
   localparam int unsigned XC_NIB_W   = 4;
   localparam int unsigned XC_NUM_BLK = 4;
   localparam logic [XC_HDR_W-1:0] XC_HDR_DATA = 2'b10;
   localparam logic [XC_HDR_W-1:0] XC_HDR_CTRL = 2'b01;
endpackage

// File: rtl/xc257_classify.sv
module xc257_classify
   import xc257_pkg::*;
#(
   parameter int unsigned NUM_BLK = XC_NUM_BLK,
   parameter int unsigned HDR_W   = XC_HDR_W,
   parameter int unsigned PAY_W   = XC_PAY_W,
   localparam int unsigned WORD_W = HDR_W + PAY_W
) (
   input  logic [NUM_BLK*WORD_W-1:0] blocks,
   output logic [NUM_BLK-1:0]        is_data,
   output logic [NUM_BLK*PAY_W-1:0]  payloads,
   output logic                      hdr_bad
);
   logic [NUM_BLK-1:0] bad_vec;

   if (HDR_W != 2) begin : g_hdr_chk
      $error("xc257_classify: sync header must be 2 bits");
   end

   for (genvar k = 0; k < NUM_BLK; k++) begin : g_blk
      logic [HDR_W-1:0] hdr;
      assign hdr                     = blocks[k*WORD_W +: HDR_W];
      assign is_data[k]              = (hdr == XC_HDR_DATA);
      assign bad_vec[k]              = (hdr != XC_HDR_DATA) && (hdr != XC_HDR_CTRL);
      assign payloads[k*PAY_W +: PAY_W] = blocks[k*WORD_W + HDR_W +: PAY_W];
   end

   assign hdr_bad = |bad_vec;
endmodule

// File: rtl/xc257_pack.sv
module xc257_pack
   import xc257_pkg::*;
#(
   parameter int unsigned NUM_BLK = XC_NUM_BLK,
   parameter int unsigned PAY_W   = XC_PAY_W,
   parameter int unsigned NIB_W   = XC_NIB_W,
   localparam int unsigned FIELD_W = NUM_BLK * PAY_W,
   localparam int unsigned OUT_W   = FIELD_W + 1
) (
   input  logic [NUM_BLK-1:0]       is_data,
   input  logic [FIELD_W-1:0]       payloads,
   output logic [OUT_W-1:0]         packed_word
);
   logic [NUM_BLK-1:0] first_ctrl;
   logic [NUM_BLK-1:0] after_first;
   logic [FIELD_W-1:0] field;
   logic               any_ctrl;

   if (NUM_BLK != NIB_W) begin : g_mask_chk
      $error("xc257_pack: mask needs one freed bit per block");
   end
   if (PAY_W < 3 * NIB_W) begin : g_pay_chk
      $error("xc257_pack: payload too narrow for a type field");
   end

   // one-hot pick of the lowest-index control block, and which blocks follow it
   for (genvar k = 0; k < NUM_BLK; k++) begin : g_first
      if (k == 0) begin : g_lo
         assign first_ctrl[k]  = ~is_data[k];
         assign after_first[k] = 1'b0;
      end else begin : g_hi
         assign first_ctrl[k]  = ~is_data[k] & (&is_data[k-1:0]);
         assign after_first[k] = |first_ctrl[k-1:0];
      end
   end

   assign any_ctrl = ~(&is_data);

   always_comb begin
      field = '0;
      for (int k = 0; k < NUM_BLK; k++) begin
         logic [PAY_W-1:0] pay;
         logic [PAY_W-1:0] part;
         int unsigned      sh;
         pay  = payloads[k*PAY_W +: PAY_W];
         part = first_ctrl[k]
                ? {{NIB_W{1'b0}}, pay[PAY_W-1:2*NIB_W], pay[NIB_W-1:0]}
                : pay;
         sh   = k * PAY_W - (after_first[k] ? NIB_W : 0);
         field = field | (FIELD_W'(part) << sh);
      end
   end

   always_comb begin
      if (any_ctrl) packed_word = {field[FIELD_W-NIB_W-1:0], is_data, 1'b0};
      else          packed_word = {field, 1'b1};
   end
endmodule

// File: rtl/xc257_transcoder.sv
module xc257_transcoder
   import xc257_pkg::*;
#(
   parameter int unsigned NUM_BLK = XC_NUM_BLK,
   parameter int unsigned HDR_W   = XC_HDR_W,
   parameter int unsigned PAY_W   = XC_PAY_W,
   parameter int unsigned NIB_W   = XC_NIB_W,
   localparam int unsigned WORD_W  = HDR_W + PAY_W,
   localparam int unsigned IN_W    = NUM_BLK * WORD_W,
   localparam int unsigned OUT_W   = NUM_BLK * PAY_W + 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   input  logic [IN_W-1:0]  in_blocks,
   output logic             out_valid,
   output logic [OUT_W-1:0] out_block,
   output logic             out_err
);
   logic [NUM_BLK-1:0]       is_data;
   logic [NUM_BLK*PAY_W-1:0] payloads;
   logic                     hdr_bad;
   logic [OUT_W-1:0]         packed_word;

   xc257_classify #(
      .NUM_BLK (NUM_BLK),
      .HDR_W   (HDR_W),
      .PAY_W   (PAY_W)
   ) u_classify (
      .blocks   (in_blocks),
      .is_data  (is_data),
      .payloads (payloads),
      .hdr_bad  (hdr_bad)
   );

   xc257_pack #(
      .NUM_BLK (NUM_BLK),
      .PAY_W   (PAY_W),
      .NIB_W   (NIB_W)
   ) u_pack (
      .is_data     (is_data),
      .payloads    (payloads),
      .packed_word (packed_word)
   );

   always_ff @(posedge clk) begin
      if (rst) out_valid <= 1'b0;
      else     out_valid <= in_valid;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         out_block <= '0;
         out_err   <= 1'b0;
      end else if (in_valid) begin
         out_block <= packed_word;
         out_err   <= hdr_bad;
      end
   end

   assert_latency_R7: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);
   assert_idle_R7: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);
   assert_reset_R8: assert property (@(posedge clk)
      rst |=> !out_valid);
   assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> ($stable(out_block) && $stable(out_err)));
   assert_mask_R3: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_block[0]) |-> !(&out_block[NUM_BLK:1]));
   assert_err_R6: assert property (@(posedge clk) disable iff (rst)
      (in_valid && hdr_bad) |=> (out_valid && out_err));
endmodule

// File: tb/xc257_transcoder_bench.sv
`timescale 1ns/1ps
module xc257_transcoder_bench;
   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         in_valid = 1'b0;
   logic [263:0] in_blocks = '0;
   logic         out_valid;
   logic [256:0] out_block;
   logic         out_err;

   int errors = 0;
   int checks = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   xc257_transcoder u_xc257_transcoder (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid),
      .in_blocks (in_blocks),
      .out_valid (out_valid),
      .out_block (out_block),
      .out_err   (out_err)
   );

   // reference: place bits one at a time in line order
   function automatic logic [256:0] ref_pack(input logic [263:0] b);
      logic [256:0] e;
      int           p;
      bit           all_d;
      bit           seen;
      e     = '0;
      all_d = 1'b1;
      seen  = 1'b0;
      for (int k = 0; k < 4; k++) if (b[66*k +: 2] != 2'b10) all_d = 1'b0;
      if (all_d) begin
         e[0] = 1'b1;
         p = 1;
      end else begin
         e[0] = 1'b0;
         for (int k = 0; k < 4; k++) e[1+k] = (b[66*k +: 2] == 2'b10);
         p = 5;
      end
      for (int k = 0; k < 4; k++) begin
         logic [63:0] pl;
         pl = b[66*k+2 +: 64];
         if (!all_d && !seen && b[66*k +: 2] != 2'b10) begin
            seen = 1'b1;
            for (int i = 0; i < 4; i++) begin e[p] = pl[i]; p++; end
            for (int i = 8; i < 64; i++) begin e[p] = pl[i]; p++; end
         end else begin
            for (int i = 0; i < 64; i++) begin e[p] = pl[i]; p++; end
         end
      end
      return e;
   endfunction

   function automatic bit ref_err(input logic [263:0] b);
      bit r = 1'b0;
      for (int k = 0; k < 4; k++)
         if (b[66*k +: 2] == 2'b00 || b[66*k +: 2] == 2'b11) r = 1'b1;
      return r;
   endfunction

   function automatic logic [263:0] make_word(input logic [1:0] h0, input logic [1:0] h1,
                                              input logic [1:0] h2, input logic [1:0] h3);
      logic [263:0] w;
      logic [1:0]   hs [4];
      hs[0] = h0; hs[1] = h1; hs[2] = h2; hs[3] = h3;
      for (int k = 0; k < 4; k++) begin
         w[66*k +: 2]      = hs[k];
         w[66*k+2 +: 32]   = $urandom;
         w[66*k+34 +: 32]  = $urandom;
      end
      return w;
   endfunction

   task automatic check1(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
      end
   endtask

   task automatic checkw(input string req, input logic [256:0] act, input logic [256:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // drive one word; output is registered at the next posedge, sampled at the negedge after
   task automatic send(input logic [263:0] w, input string req);
      @(negedge clk);
      in_blocks = w;
      in_valid  = 1'b1;
      @(negedge clk);
      in_valid  = 1'b0;
      check1({req, " valid (R7)"}, out_valid, 1'b1);
      checkw(req, out_block, ref_pack(w));
      check1({req, " err (R6)"}, out_err, ref_err(w));
   endtask

   initial begin
      logic [256:0] held;
      logic [263:0] w;
      void'($urandom(32'h5EED_257B));
      repeat (3) @(negedge clk);
      check1("R8 reset valid", out_valid, 1'b0);
      rst = 1'b0;
      @(negedge clk);
      check1("R7 idle after reset", out_valid, 1'b0);

      send(make_word(2'b10, 2'b10, 2'b10, 2'b10), "R2 all data");
      w = make_word(2'b01, 2'b10, 2'b10, 2'b10);
      w[66*0+2 +: 8] = 8'h1E;
      send(w, "R4 CB first");
      checkw("R3 mask 0111", {252'd0, out_block[4:0]}, {252'd0, 5'b11100});
      send(make_word(2'b10, 2'b01, 2'b01, 2'b01), "R5 DB then CBs");
      checkw("R3 mask 1000", {252'd0, out_block[4:0]}, {252'd0, 5'b00010});
      send(make_word(2'b01, 2'b01, 2'b01, 2'b01), "R5 all control");
      send(make_word(2'b10, 2'b10, 2'b10, 2'b01), "R4 CB last");
      send(make_word(2'b10, 2'b11, 2'b01, 2'b10), "R6 bad before first CB");
      send(make_word(2'b10, 2'b01, 2'b00, 2'b10), "R6 bad after first CB");
      send(make_word(2'b00, 2'b10, 2'b10, 2'b10), "R1 bad as control");

      // hold with no valid input
      held = out_block;
      repeat (4) @(negedge clk);
      checkw("R9 hold", out_block, held);
      check1("R9 err hold", out_err, 1'b1);
      check1("R7 no valid when idle", out_valid, 1'b0);

      for (int n = 0; n < 300; n++) begin
         logic [1:0] hs [4];
         for (int k = 0; k < 4; k++) begin
            int r;
            r = $urandom_range(0, 99);
            hs[k] = (r < 55) ? 2'b10 : (r < 92) ? 2'b01 : (r < 96) ? 2'b00 : 2'b11;
         end
         send(make_word(hs[0], hs[1], hs[2], hs[3]), "R2 R3 R4 R5 random");
      end

      // back-to-back and reset mid-stream
      @(negedge clk);
      in_blocks = make_word(2'b10, 2'b10, 2'b10, 2'b10);
      in_valid  = 1'b1;
      @(negedge clk);
      check1("R7 back-to-back 1", out_valid, 1'b1);
      rst = 1'b1;
      @(negedge clk);
      check1("R8 reset mid-stream", out_valid, 1'b0);
      rst = 1'b0;
      in_valid = 1'b0;
      @(negedge clk);
      check1("R8 idle after reset", out_valid, 1'b0);
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (100000) @(posedge clk);
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=done");
         end
      join_any
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule